// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block drains a ring of transmit descriptors that software builds in memory and turns the referenced buffers into an outgoing byte stream. Each descriptor occupies two words: a byte pointer to a buffer, then a control word. The control word gives the fragment length and says whether the fragment closes a frame. Software fills a descriptor and then moves its produce index forward. The engine works through the ring for as long as its own consume index differs from the produce index. After each descriptor it writes one status word to a separate status array and then steps its consume index, wrapping to slot zero after the last slot.

Configuration and the two ring indices are plain pins. The memory side is a single word-wide port. A request is held, with address, direction and write data stable, until the memory answers with `mem_ack`. For a read, `mem_rdata` is taken in the acknowledge cycle.

The byte stream uses valid/ready. A byte transfers on a clock edge where `tx_valid` and `tx_ready` are both high. While `tx_valid` is high and `tx_ready` is low, the data and the last flag hold and valid stays high. The engine never withdraws a byte it has offered. Cycles with `tx_valid` low may fall between words while the next memory read completes, but no filler bytes are ever inserted.

Top module: `tx_desc_ring_engine`

## Requirements
- R1: After reset, `hw_consume` is 0, `tx_valid` is low and `mem_req` is low.
- R2: While `hw_consume` equals `sw_produce`, the engine issues no memory request and offers no bytes.
- R3: For the descriptor at slot i, the engine reads the pointer word at `desc_base + 8*i` and then the control word at `desc_base + 8*i + 4`. Control bits 10:0 hold the fragment length in bytes minus one.
- R4: A fragment produces exactly length bytes, taken from consecutive byte addresses starting at the pointer, which may be unaligned. Bytes are little-endian within a word: the byte at address a comes from bits 8*(a mod 4)+7 down to 8*(a mod 4) of the word at a with its two low bits cleared.
- R5: `tx_last` is high only with `tx_valid`, and only on the final byte of a fragment whose control bit 30 is set. A frame built from several fragments has exactly one last byte.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold in the next cycle.
- R7: When a descriptor's final byte has transferred, the engine writes one status word of value 0x8000_0000 (bit 31 marks completion, every other bit is zero) to `stat_base + 4*i`.
- R8: `hw_consume` advances by one only in the cycle after its status write is acknowledged, and it goes to 0 after slot `last_idx`.
- R9: A new descriptor starts only while `tx_enable` is high. A descriptor already started runs to its status write even if `tx_enable` falls.
- R10: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_addr` and `mem_we` hold in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_enable | input | 1 | Transmit enable; checked before each descriptor |
| desc_base | input | ADDR_W | Byte address of descriptor slot 0 |
| stat_base | input | ADDR_W | Byte address of status slot 0 |
| last_idx | input | IDX_W | Highest slot number (slot count minus one) |
| sw_produce | input | IDX_W | Software produce index |
| hw_consume | output | IDX_W | Engine consume index |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Write data (status word) |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Sink accepts byte |
| tx_last | output | 1 | Final byte of a frame |

## Verification
The bench covers pointers that start at every byte lane. An engine that misaligned the first word would emit bytes from the wrong address, and one that chose fragment lengths wrongly would drop or repeat bytes at word boundaries. A two-fragment frame checks that only the closing fragment carries `tx_last`; an engine that marked every fragment would end the frame early. A batch that crosses the top slot checks the wrap of both the consume index and the status address. A run with random ready and acknowledge stalls exposes any byte lost or duplicated under back-pressure. Dropping enable in the middle of a descriptor must neither abort that descriptor nor let the next one start.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PTR,
    ST_CTL,
    ST_WORD,
    ST_BYTES,
    ST_STAT
  } tdr_state_e;

  localparam logic [31:0] STATUS_DONE  = 32'h8000_0000;
  localparam int          CTL_LAST_BIT = 30;
endpackage

// File: rtl/tdr_ring_idx.sv
module tdr_ring_idx #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] last_idx,
  input  logic [IDX_W-1:0] produce,
  input  logic             advance,
  output logic [IDX_W-1:0] consume,
  output logic             pending
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (advance) begin
      if (idx_q == last_idx) idx_q <= '0;
      else                   idx_q <= idx_q + 1'b1;
    end
  end

  assign consume = idx_q;
  assign pending = (idx_q != produce);
endmodule

// File: rtl/tdr_unpack.sv
module tdr_unpack #(
  parameter int WORD_W = 32,
  localparam int LANES  = WORD_W / 8,
  localparam int LANE_W = $clog2(LANES),
  localparam int CNT_W  = LANE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic [LANE_W-1:0] load_off,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic              load_eop,
  output logic [7:0]        out_data,
  output logic              out_valid,
  output logic              out_last,
  input  logic              out_ready,
  output logic              drained
);
  logic [WORD_W-1:0] word_q;
  logic [LANE_W-1:0] off_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              eop_q;
  logic              fire;

  assign out_valid = (cnt_q != '0);
  assign fire      = out_valid && out_ready;
  assign out_data  = word_q[8*off_q +: 8];
  assign out_last  = eop_q && (cnt_q == CNT_W'(1));
  assign drained   = fire && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      off_q  <= '0;
      cnt_q  <= '0;
      eop_q  <= 1'b0;
    end else if (load) begin
      word_q <= load_word;
      off_q  <= load_off;
      cnt_q  <= load_cnt;
      eop_q  <= load_eop;
    end else if (fire) begin
      off_q <= off_q + 1'b1;
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/tdr_ctrl.sv
module tdr_ctrl
  import tdr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int SIZE_W = 11,
  localparam int REM_W = SIZE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_enable,
  input  logic              pending,
  input  logic [IDX_W-1:0]  slot,
  input  logic [ADDR_W-1:0] desc_base,
  input  logic [ADDR_W-1:0] stat_base,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              advance,
  output logic              ld,
  output logic [31:0]       ld_word,
  output logic [1:0]        ld_off,
  output logic [2:0]        ld_cnt,
  output logic              ld_eop,
  input  logic              drained
);
  tdr_state_e        state_q;
  logic [ADDR_W-1:0] cur_q;
  logic [REM_W-1:0]  rem_q;
  logic              last_q;

  logic [ADDR_W-1:0] desc_addr;
  logic [ADDR_W-1:0] stat_addr;
  logic [2:0]        avail;
  logic [2:0]        take;
  logic [REM_W-1:0]  rem_next;

  assign desc_addr = desc_base + {{(ADDR_W-IDX_W-3){1'b0}}, slot, 3'b000};
  assign stat_addr = stat_base + {{(ADDR_W-IDX_W-2){1'b0}}, slot, 2'b00};
  assign avail     = 3'd4 - {1'b0, cur_q[1:0]};
  assign take      = (rem_q < REM_W'(avail)) ? rem_q[2:0] : avail;
  assign rem_next  = rem_q - REM_W'(take);

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state_q)
      ST_PTR:  begin mem_req = 1'b1; mem_addr = desc_addr; end
      ST_CTL:  begin mem_req = 1'b1; mem_addr = desc_addr + ADDR_W'(4); end
      ST_WORD: begin mem_req = 1'b1; mem_addr = {cur_q[ADDR_W-1:2], 2'b00}; end
      ST_STAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = stat_addr;
        mem_wdata = STATUS_DONE;
      end
      default: ;
    endcase
  end

  assign ld      = (state_q == ST_WORD) && mem_ack;
  assign ld_word = mem_rdata;
  assign ld_off  = cur_q[1:0];
  assign ld_cnt  = take;
  assign ld_eop  = last_q && (rem_next == '0);
  assign advance = (state_q == ST_STAT) && mem_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      rem_q   <= '0;
      last_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE:
          if (tx_enable && pending) state_q <= ST_PTR;
        ST_PTR:
          if (mem_ack) begin
            cur_q   <= mem_rdata[ADDR_W-1:0];
            state_q <= ST_CTL;
          end
        ST_CTL:
          if (mem_ack) begin
            rem_q   <= REM_W'(mem_rdata[SIZE_W-1:0]) + REM_W'(1);
            last_q  <= mem_rdata[CTL_LAST_BIT];
            state_q <= ST_WORD;
          end
        ST_WORD:
          if (mem_ack) begin
            rem_q   <= rem_next;
            cur_q   <= {cur_q[ADDR_W-1:2] + 1'b1, 2'b00};
            state_q <= ST_BYTES;
          end
        ST_BYTES:
          if (drained) state_q <= (rem_q == '0) ? ST_STAT : ST_WORD;
        ST_STAT:
          if (mem_ack) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_desc_ring_engine.sv
module tx_desc_ring_engine #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int SIZE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_enable,
  input  logic [ADDR_W-1:0] desc_base,
  input  logic [ADDR_W-1:0] stat_base,
  input  logic [IDX_W-1:0]  last_idx,
  input  logic [IDX_W-1:0]  sw_produce,
  output logic [IDX_W-1:0]  hw_consume,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_last
);
  logic        pending;
  logic        advance;
  logic        ld;
  logic [31:0] ld_word;
  logic [1:0]  ld_off;
  logic [2:0]  ld_cnt;
  logic        ld_eop;
  logic        drained;

  tdr_ring_idx #(.IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .last_idx(last_idx), .produce(sw_produce),
    .advance(advance), .consume(hw_consume), .pending(pending)
  );

  tdr_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SIZE_W(SIZE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .pending(pending),
    .slot(hw_consume), .desc_base(desc_base), .stat_base(stat_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .advance(advance), .ld(ld), .ld_word(ld_word), .ld_off(ld_off),
    .ld_cnt(ld_cnt), .ld_eop(ld_eop), .drained(drained)
  );

  tdr_unpack #(.WORD_W(32)) u_unpack (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_word(ld_word),
    .load_off(ld_off), .load_cnt(ld_cnt), .load_eop(ld_eop),
    .out_data(tx_data), .out_valid(tx_valid), .out_last(tx_last),
    .out_ready(tx_ready), .drained(drained)
  );
endmodule

// File: rtl/tdr_checker.sv
module tdr_checker #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              tx_last,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [IDX_W-1:0]  hw_consume,
  input logic [IDX_W-1:0]  sw_produce
);
  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R8
  consume_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hw_consume) |-> $past(mem_req && mem_we && mem_ack));

  // R2
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_consume == sw_produce) |-> (!mem_req && !tx_valid));

  // R5
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);
endmodule

bind tx_desc_ring_engine tdr_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_last(tx_last), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .hw_consume(hw_consume),
  .sw_produce(sw_produce)
);

// File: tb/tx_desc_ring_engine_test.sv
module tx_desc_ring_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] DBASE = 32'h100;
  localparam logic [31:0] SBASE = 32'h180;
  localparam logic [31:0] LASTF = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_enable = 1'b0;
  logic [7:0]  sw_produce = '0;
  logic [7:0]  hw_consume;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_last;
  logic        tx_ready = 1'b1;
  logic        ack_en = 1'b1;
  logic        slow = 1'b0;
  logic [7:0]  lfsr = 8'hA5;

  logic [31:0] mem [0:255];
  logic [7:0]  cap_d [0:255];
  logic        cap_l [0:255];
  int          cap_n = 0;
  logic [31:0] st_a [0:63];
  logic [31:0] st_d [0:63];
  int          st_n = 0;
  int          req_n = 0;
  int          checks = 0;
  int          errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_desc_ring_engine uut (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable),
    .desc_base(DBASE), .stat_base(SBASE), .last_idx(8'd3),
    .sw_produce(sw_produce), .hw_consume(hw_consume),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_last(tx_last)
  );

  assign mem_ack   = mem_req && ack_en;
  assign mem_rdata = mem[mem_addr[9:2]];

  always @(negedge clk) begin
    lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready <= slow ? lfsr[0] : 1'b1;
    ack_en   <= slow ? (lfsr[3] | lfsr[1]) : 1'b1;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (tx_valid && tx_ready) begin
        cap_d[cap_n] <= tx_data;
        cap_l[cap_n] <= tx_last;
        cap_n <= cap_n + 1;
      end
      if (mem_req && mem_we && mem_ack) begin
        st_a[st_n] <= mem_addr;
        st_d[st_n] <= mem_wdata;
        st_n <= st_n + 1;
      end
      if (mem_req) req_n <= req_n + 1;
    end
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 49) & 255);
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic set_desc(input int slot, input logic [31:0] ptr, input logic [31:0] ctl);
    mem[64 + 2*slot] = ptr;
    mem[65 + 2*slot] = ctl;
  endtask

  task automatic wait_consume(input logic [7:0] target);
    for (int k = 0; k < 3000; k++) begin
      if (hw_consume == target) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic cmp_frag(input int base, input int ptr, input int len, input bit eop,
                          input string tag);
    for (int k = 0; k < len; k++) begin
      chk(cap_d[base+k] == pat(ptr+k), {tag, " R4 byte"}, 32'(cap_d[base+k]), 32'(pat(ptr+k)));
      chk(cap_l[base+k] == (eop && k == len-1), {tag, " R5 last"},
          32'(cap_l[base+k]), 32'(eop && k == len-1));
    end
  endtask

  task automatic t_reset();
    chk(hw_consume == 0, "R1 consume", 32'(hw_consume), 0);
    chk(!tx_valid, "R1 tx_valid", 32'(tx_valid), 0);
    chk(!mem_req, "R1 mem_req", 32'(mem_req), 0);
  endtask

  task automatic t_idle();
    int r0 = req_n;
    tx_enable = 1'b1;
    repeat (20) @(negedge clk);
    chk(req_n == r0, "R2 no request when empty", 32'(req_n - r0), 0);
    chk(cap_n == 0, "R2 no bytes when empty", 32'(cap_n), 0);
  endtask

  task automatic t_single();
    int c0 = cap_n, s0 = st_n;
    set_desc(0, 32'h000, LASTF | 32'd5);
    sw_produce = 8'd1;
    wait_consume(8'd1);
    chk(hw_consume == 1, "R3 R8 consume after one", 32'(hw_consume), 1);
    chk(cap_n - c0 == 6, "R3 R4 byte count", 32'(cap_n - c0), 6);
    cmp_frag(c0, 32'h000, 6, 1'b1, "single");
    chk(st_n - s0 == 1, "R7 one status", 32'(st_n - s0), 1);
    chk(st_a[s0] == SBASE, "R7 status addr", st_a[s0], SBASE);
    chk(st_d[s0] == 32'h8000_0000, "R7 status value", st_d[s0], 32'h8000_0000);
  endtask

  task automatic t_multi();
    int c0 = cap_n, s0 = st_n;
    slow = 1'b1;
    set_desc(1, 32'h013, 32'd2);
    set_desc(2, 32'h041, LASTF | 32'd4);
    sw_produce = 8'd3;
    wait_consume(8'd3);
    slow = 1'b0;
    chk(cap_n - c0 == 8, "R4 R6 count under stalls", 32'(cap_n - c0), 8);
    cmp_frag(c0, 32'h013, 3, 1'b0, "frag1");
    cmp_frag(c0 + 3, 32'h041, 5, 1'b1, "frag2");
    chk(st_n - s0 == 2, "R7 two statuses", 32'(st_n - s0), 2);
    chk(st_a[s0] == SBASE + 4, "R7 status slot1", st_a[s0], SBASE + 4);
    chk(st_a[s0+1] == SBASE + 8, "R7 status slot2", st_a[s0+1], SBASE + 8);
  endtask

  task automatic t_wrap();
    int c0 = cap_n, s0 = st_n;
    set_desc(3, 32'h0A2, LASTF);
    set_desc(0, 32'h0C7, LASTF | 32'd1);
    sw_produce = 8'd1;
    wait_consume(8'd1);
    chk(hw_consume == 1, "R8 consume after wrap", 32'(hw_consume), 1);
    chk(cap_n - c0 == 3, "R4 wrap byte count", 32'(cap_n - c0), 3);
    cmp_frag(c0, 32'h0A2, 1, 1'b1, "wrap3");
    cmp_frag(c0 + 1, 32'h0C7, 2, 1'b1, "wrap0");
    chk(st_a[s0] == SBASE + 12, "R8 status top slot", st_a[s0], SBASE + 12);
    chk(st_a[s0+1] == SBASE, "R8 status slot0 after wrap", st_a[s0+1], SBASE);
  endtask

  task automatic t_enable();
    int c0 = cap_n, r0 = req_n;
    tx_enable = 1'b0;
    set_desc(1, 32'h080, LASTF | 32'd7);
    sw_produce = 8'd2;
    repeat (30) @(negedge clk);
    chk(req_n == r0, "R9 disabled no request", 32'(req_n - r0), 0);
    chk(hw_consume == 1, "R9 disabled consume holds", 32'(hw_consume), 1);
    tx_enable = 1'b1;
    for (int k = 0; k < 200; k++) begin
      if (tx_valid) break;
      @(negedge clk);
    end
    tx_enable = 1'b0;
    set_desc(2, 32'h0E0, LASTF | 32'd1);
    sw_produce = 8'd3;
    wait_consume(8'd2);
    repeat (30) @(negedge clk);
    chk(hw_consume == 2, "R9 in-flight finishes, next held", 32'(hw_consume), 2);
    chk(cap_n - c0 == 8, "R9 full descriptor sent", 32'(cap_n - c0), 8);
    cmp_frag(c0, 32'h080, 8, 1'b1, "enable");
    tx_enable = 1'b1;
    wait_consume(8'd3);
    chk(hw_consume == 3, "R9 resumes on enable", 32'(hw_consume), 3);
    cmp_frag(c0 + 8, 32'h0E0, 2, 1'b1, "resume");
  endtask

  initial begin
    for (int w = 0; w < 256; w++)
      mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_single();
    t_multi();
    t_wrap();
    t_enable();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule